// File: doc/BRIEF.md
# Memory-Mapped Multiply-Accumulate Unit

This peripheral performs multiplication and multiply-accumulate for a processor that reaches it over a simple register bus. The bus has an address, a write strobe, a byte/word flag, write data and read data. The first operand can be written at four addresses. The address used selects one of four operations: unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. Writing the second operand starts the selected operation on the operand that is being written.

The 32-bit result sits in a low word and a high word. A third register, the extension word, holds either the sign of the result or the carry out of an unsigned accumulation. The result is written in the same clock edge that accepts the second operand, so the next bus access reads it with no wait cycles. Any operand can be 8 bits wide when it is written with a byte access, so 16x16, 16x8, 8x16 and 8x8 products all work. Software can write the result registers directly, which presets the accumulator before a chain of accumulations.

Top module: `mac_periph`

## Requirements
- R1: After reset, the low, high and extension result words are 0. Both operand registers also read back 0, and the selected operation is unsigned multiply.
- R2: The bus uses these word indices. Index 0 is the first operand with unsigned multiply, 1 is the first operand with signed multiply, 2 is the first operand with unsigned accumulate, and 3 is the first operand with signed accumulate. Index 4 is the second operand and starts the operation. Indices 5, 6 and 7 are the low, high and extension result words. A read at any of indices 0 to 3 returns the first operand.
- R3: Unsigned multiply writes the 32-bit unsigned product to the result words and sets the extension word to 0x0000.
- R4: Signed multiply writes the two's-complement product of the two operands. The extension word is 0xFFFF when the product is negative and 0x0000 otherwise.
- R5: Unsigned accumulate adds the unsigned product to the 32-bit value held in the result words and keeps the lower 32 bits. The extension word is set to 1 when that sum carries out of bit 31 and to 0 otherwise.
- R6: Signed accumulate adds the signed product to the signed 32-bit result and wraps at 32 bits. The extension word is 0xFFFF when bit 31 of the new result is set and 0x0000 otherwise.
- R7: A byte write (byte flag = 1) uses data bits 7:0. Those bits are sign-extended to 16 bits when the operation is signed and zero-extended when it is unsigned. For the first operand, the operation is the one named by the index being written. For the second operand, it is the operation currently selected.
- R8: The result of a second-operand write can be read on the very next bus access after that write.
- R9: The result words can be written, which presets the accumulator. A byte write to a result word zero-extends the byte.
- R10: Writing the first operand alone leaves all three result words unchanged. The result words also hold their values through any cycle that writes neither the second operand nor a result word.
- R11: Writing the second operand again repeats the selected operation with the first operand that is held. In an accumulate mode this adds the product a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Register word index |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_byte | input | 1 | 1 = byte access using data bits 7:0 |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for the indexed register (combinational) |

## Verification
A wrong mode register shows up on the first read after the next second-operand write. The low, high or extension word would carry a sign error or a missing or spurious accumulation. Because accumulations are chained, a bad carry or a bad result register corrupts every later read in a sweep, not just one. A wrong byte extension shows at once when the first operand is read back, before any product is formed.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [1:0] {
      OP_UMUL = 2'd0,
      OP_SMUL = 2'd1,
      OP_UMAC = 2'd2,
      OP_SMAC = 2'd3
   } mac_op_t;

   localparam int unsigned IDX_OPB = 4;
   localparam int unsigned IDX_LO  = 5;
   localparam int unsigned IDX_HI  = 6;
   localparam int unsigned IDX_EXT = 7;

   function automatic logic op_signed(input mac_op_t op);
      return op[0];
   endfunction

   function automatic logic op_accum(input mac_op_t op);
      return op[1];
   endfunction
endpackage

// File: rtl/mac_byte_ext.sv
module mac_byte_ext #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] raw,
   input  logic              byte_en,
   input  logic              sign_en,
   output logic [DATA_W-1:0] value
);
   localparam int PAD_W = DATA_W - BYTE_W;

   generate
      if (PAD_W == 0) begin : g_same
         logic unused_ctl;
         assign unused_ctl = byte_en ^ sign_en;
         assign value = raw;
      end else begin : g_extend
         logic fill;
         assign fill  = sign_en & raw[BYTE_W-1];
         assign value = byte_en ? {{PAD_W{fill}}, raw[BYTE_W-1:0]} : raw;
      end
   endgenerate
endmodule

// File: rtl/mac_core.sv
module mac_core
   import mac_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  mac_op_t           op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] acc_lo,
   input  logic [DATA_W-1:0] acc_hi,
   output logic [DATA_W-1:0] res_lo,
   output logic [DATA_W-1:0] res_hi,
   output logic [DATA_W-1:0] res_ext
);
   localparam int PROD_W = 2 * DATA_W;

   logic [PROD_W-1:0] a_wide, b_wide, prod, acc, total;
   logic [PROD_W:0]   sum;
   logic              sgn;

   always_comb begin
      sgn    = op_signed(op);
      a_wide = {{DATA_W{sgn & opa[DATA_W-1]}}, opa};
      b_wide = {{DATA_W{sgn & opb[DATA_W-1]}}, opb};
      prod   = a_wide * b_wide;
      acc    = {acc_hi, acc_lo};
      sum    = {1'b0, acc} + {1'b0, prod};
      total  = op_accum(op) ? sum[PROD_W-1:0] : prod;
      res_lo = total[DATA_W-1:0];
      res_hi = total[PROD_W-1:DATA_W];
      if (sgn)
         res_ext = {DATA_W{total[PROD_W-1]}};
      else if (op_accum(op))
         res_ext = {{(DATA_W-1){1'b0}}, sum[PROD_W]};
      else
         res_ext = '0;
   end
endmodule

// File: rtl/mac_rdmux.sv
module mac_rdmux
   import mac_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] ext,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      if (addr < ADDR_W'(IDX_OPB))          rdata = opa;
      else if (addr == ADDR_W'(IDX_OPB))    rdata = opb;
      else if (addr == ADDR_W'(IDX_LO))     rdata = lo;
      else if (addr == ADDR_W'(IDX_HI))     rdata = hi;
      else if (addr == ADDR_W'(IDX_EXT))    rdata = ext;
      else                                  rdata = '0;
   end
endmodule

// File: rtl/mac_periph.sv
module mac_periph
   import mac_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_byte,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("mac_periph: ADDR_W must be at least 3");
   end
   if (BYTE_W < 1 || BYTE_W > DATA_W) begin : g_bad_byte
      $error("mac_periph: BYTE_W must lie in 1..DATA_W");
   end

   mac_op_t           mode_q;
   logic [DATA_W-1:0] opa_q, opb_q, lo_q, hi_q, ext_q;
   logic [DATA_W-1:0] opa_in, opb_in, res_in;
   logic [DATA_W-1:0] nx_lo, nx_hi, nx_ext;
   mac_op_t           sel_op;
   logic              wr_opa, wr_opb, wr_lo, wr_hi, wr_ext;

   assign sel_op = mac_op_t'(bus_addr[1:0]);
   assign wr_opa = bus_we && (bus_addr <  ADDR_W'(IDX_OPB));
   assign wr_opb = bus_we && (bus_addr == ADDR_W'(IDX_OPB));
   assign wr_lo  = bus_we && (bus_addr == ADDR_W'(IDX_LO));
   assign wr_hi  = bus_we && (bus_addr == ADDR_W'(IDX_HI));
   assign wr_ext = bus_we && (bus_addr == ADDR_W'(IDX_EXT));

   mac_byte_ext #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext_a (
      .raw(bus_wdata), .byte_en(bus_byte), .sign_en(op_signed(sel_op)), .value(opa_in));
   mac_byte_ext #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext_b (
      .raw(bus_wdata), .byte_en(bus_byte), .sign_en(op_signed(mode_q)), .value(opb_in));
   mac_byte_ext #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext_r (
      .raw(bus_wdata), .byte_en(bus_byte), .sign_en(1'b0), .value(res_in));

   mac_core #(.DATA_W(DATA_W)) u_core (
      .op(mode_q), .opa(opa_q), .opb(opb_in), .acc_lo(lo_q), .acc_hi(hi_q),
      .res_lo(nx_lo), .res_hi(nx_hi), .res_ext(nx_ext));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= OP_UMUL;
         opa_q  <= '0;
         opb_q  <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         ext_q  <= '0;
      end else begin
         if (wr_opa) begin
            mode_q <= sel_op;
            opa_q  <= opa_in;
         end
         if (wr_opb) begin
            opb_q <= opb_in;
            lo_q  <= nx_lo;
            hi_q  <= nx_hi;
            ext_q <= nx_ext;
         end
         if (wr_lo)  lo_q  <= res_in;
         if (wr_hi)  hi_q  <= res_in;
         if (wr_ext) ext_q <= res_in;
      end
   end

   mac_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .addr(bus_addr), .opa(opa_q), .opb(opb_q), .lo(lo_q), .hi(hi_q), .ext(ext_q),
      .rdata(bus_rdata));
endmodule

// File: rtl/mac_periph_chk.sv
module mac_periph_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        mode_q,
   input logic [DATA_W-1:0] lo_q,
   input logic [DATA_W-1:0] hi_q,
   input logic [DATA_W-1:0] ext_q
);
   logic trig, res_wr;
   assign trig   = bus_we && (bus_addr == ADDR_W'(4));
   assign res_wr = bus_we && (bus_addr >= ADDR_W'(5)) && (bus_addr <= ADDR_W'(7));

   assert_mode_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr < ADDR_W'(4)) |=> (mode_q == $past(bus_addr[1:0])));

   assert_umul_ext_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_q == 2'd0) |=> (ext_q == '0));

   assert_smul_ext_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_q == 2'd1) |=> (ext_q == {DATA_W{hi_q[DATA_W-1]}}));

   assert_umac_carry_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_q == 2'd2) |=> (ext_q <= DATA_W'(1)));

   assert_smac_ext_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_q == 2'd3) |=> (ext_q == {DATA_W{hi_q[DATA_W-1]}}));

   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig || res_wr) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ext_q)));
endmodule

bind mac_periph mac_periph_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .mode_q(mode_q), .lo_q(lo_q), .hi_q(hi_q), .ext_q(ext_q));

// File: tb/mac_periph_test.sv
module mac_periph_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic        bus_byte = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;

   int checks = 0;
   int fails = 0;
   logic [31:0] acc;
   logic [15:0] vals [16];

   always #5 clk = ~clk;

   mac_periph uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic b);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_byte = b; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_byte = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   // Arithmetic model: returns {ext, hi, lo}
   function automatic logic [47:0] model(input logic [1:0] op, input logic [15:0] a,
                                         input logic [15:0] b, input logic [31:0] prev);
      longint p, t;
      logic [31:0] r;
      logic [15:0] e;
      if (op[0]) p = longint'($signed(a)) * longint'($signed(b));
      else       p = longint'(a) * longint'(b);
      if (!op[1]) t = p;
      else if (op[0]) t = longint'($signed(prev)) + p;
      else t = longint'(prev) + p;
      r = t[31:0];
      if (op[0])      e = r[31] ? 16'hFFFF : 16'h0000;
      else if (op[1]) e = {15'd0, t[32]};
      else            e = 16'h0000;
      return {e, r};
   endfunction

   function automatic string tag(input logic [1:0] op);
      case (op)
         2'd0: return "R3 umul";
         2'd1: return "R4 smul";
         2'd2: return "R5 umac";
         default: return "R6 smac";
      endcase
   endfunction

   task automatic read_result(output logic [47:0] r);
      logic [15:0] l, h, e;
      rd(3'd5, l); rd(3'd6, h); rd(3'd7, e);
      r = {e, h, l};
   endtask

   initial begin
      logic [15:0] d;
      logic [47:0] r, exp;
      vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF, 16'h0080,
               16'h1234, 16'hABCD, 16'h007F, 16'hFF00, 16'h0003, 16'h5555, 16'hAAAA, 16'h8001};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_result(r);
      check("R1 results after reset", r, 48'h0);
      rd(3'd0, d); check("R1 first operand after reset", {32'h0, d}, 48'h0);
      rd(3'd4, d); check("R1 second operand after reset", {32'h0, d}, 48'h0);

      // Word sweeps over all four operations (R3..R6, R8)
      for (int op = 0; op < 4; op++) begin
         acc = (op == 2) ? 32'hFFFF_FFF0 : (op == 3) ? 32'h7FFF_FFF0 : 32'h0;
         wr(3'd5, acc[15:0], 1'b0);
         wr(3'd6, acc[31:16], 1'b0);
         read_result(r);
         check("R9 preset readback", r[31:0], {16'h0, acc});
         for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
               wr(3'(op), vals[i], 1'b0);
               wr(3'd4, vals[j], 1'b0);
               read_result(r);            // R8: first access after the trigger
               exp = model(2'(op), vals[i], vals[j], acc);
               check(tag(2'(op)), r, exp);
               acc = exp[31:0];
            end
         end
      end

      // R2 read of every first-operand index and of the second operand
      wr(3'd2, 16'hBEEF, 1'b0);
      for (int k = 0; k < 4; k++) begin
         rd(3'(k), d); check("R2 first operand readback", {32'h0, d}, {32'h0, 16'hBEEF});
      end
      wr(3'd4, 16'h0002, 1'b0);
      rd(3'd4, d); check("R2 second operand readback", {32'h0, d}, {32'h0, 16'h0002});

      // R10 first operand write leaves results
      read_result(exp);
      wr(3'd1, 16'h4321, 1'b0);
      wr(3'd3, 16'h8765, 1'b0);
      @(negedge clk);
      read_result(r);
      check("R10 results held over operand-1 writes", r, exp);

      // R11 repeated trigger accumulates again (unsigned MAC)
      wr(3'd5, 16'h0000, 1'b0);
      wr(3'd6, 16'h0000, 1'b0);
      wr(3'd7, 16'h0000, 1'b0);
      wr(3'd2, 16'h0100, 1'b0);
      wr(3'd4, 16'h0300, 1'b0);
      wr(3'd4, 16'h0300, 1'b0);
      read_result(r);
      check("R11 double accumulate", r, {16'h0, 32'h0006_0000});

      // R9 byte write to a result word is zero-extended
      wr(3'd5, 16'hAB80, 1'b1);
      rd(3'd5, d); check("R9 byte preset zero-extended", {32'h0, d}, {32'h0, 16'h0080});

      // R7 byte operands in all modes: a-byte, b-byte, both
      for (int op = 0; op < 4; op++) begin
         wr(3'd5, 16'h0, 1'b0); wr(3'd6, 16'h0, 1'b0);
         acc = 32'h0;
         for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 16; i++) begin
               for (int j = 0; j < 16; j += 3) begin
                  logic [15:0] ra, rb, ea, eb;
                  ra = {vals[j][7:0], vals[i][7:0]};
                  rb = {vals[i][15:8], vals[j][7:0]};
                  ea = (k != 1) ? (op[0] ? {{8{ra[7]}}, ra[7:0]} : {8'h00, ra[7:0]}) : ra;
                  eb = (k != 0) ? (op[0] ? {{8{rb[7]}}, rb[7:0]} : {8'h00, rb[7:0]}) : rb;
                  wr(3'(op), ra, k != 1);
                  rd(3'(op), d);
                  check("R7 operand-1 byte extension", {32'h0, d}, {32'h0, ea});
                  wr(3'd4, rb, k != 0);
                  rd(3'd4, d);
                  check("R7 operand-2 byte extension", {32'h0, d}, {32'h0, eb});
                  read_result(r);
                  exp = model(2'(op), ea, eb, acc);
                  check("R7 byte-width product", r, exp);
                  acc = exp[31:0];
               end
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule